// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Write Protection

This block holds a small set of recent page translations and turns a virtual address into a physical address within the same cycle. Every stored entry is compared with the virtual page number of the request at once. On a match, the physical page number of that entry is joined to the untouched page offset. A request that matches nothing raises a miss exception. A write that matches an entry without write permission raises a write-protection exception. In neither case is a physical address given.

Each entry also keeps a dirty flag. The first permitted write to the page sets it, and the lookup reports it. Whatever resolves a miss, whether software or an external walker, loads the result through a fill port. A fill for a page that is already held overwrites that entry. Otherwise the fill takes the lowest free slot or, when the buffer is full, a round-robin victim. A single invalidate-all input empties the buffer.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, so every lookup raises the miss exception.
- R2: A lookup that hits produces, in the same cycle, resp_hit=1 and resp_paddr = {stored physical page, req_vaddr[11:0]}. The page offset is the low 12 bits and is copied unchanged.
- R3: A lookup that matches no valid entry gives resp_miss_exc=1, resp_hit=0, resp_wprot_exc=0 and resp_paddr=0.
- R4: A write lookup (req_write=1) that matches an entry with its write-permission bit clear gives resp_wprot_exc=1, resp_hit=0 and resp_paddr=0, and leaves that entry's dirty flag clear. A read lookup of the same entry hits.
- R5: resp_dirty shows the dirty flag of the matched entry. The flag becomes 1 at the clock edge that ends the first permitted write hit, and a fill of that entry clears it.
- R6: While free slots remain, a fill of a new page takes the lowest-indexed free slot, so 32 distinct pages can be resident together.
- R7: When all 32 slots are valid, a fill of a new page replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, with each such replacement.
- R8: A fill whose virtual page is already resident overwrites that entry's physical page and permission and clears its dirty flag. No second copy is made.
- R9: Invalidate-all clears every entry at one clock edge and overrides a fill in the same cycle.
- R10: A lookup in the same cycle as a fill sees the contents from before that fill.
- R11: With req_valid=0, resp_hit, resp_miss_exc, resp_wprot_exc, resp_dirty and resp_paddr are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 40 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| resp_hit | output | 1 | Translation succeeded |
| resp_paddr | output | 32 | Physical address, 0 unless hit |
| resp_miss_exc | output | 1 | No matching entry |
| resp_wprot_exc | output | 1 | Write to a non-writable page |
| resp_dirty | output | 1 | Dirty flag of the matched entry |
| fill_valid | input | 1 | Load an entry |
| fill_vpn | input | 28 | Virtual page number to load |
| fill_ppn | input | 20 | Physical page number to load |
| fill_writable | input | 1 | Write permission of the loaded page |
| inval_all | input | 1 | Clear every entry |

## Verification
All lookup results are combinational on the stored state, so they are due in the same cycle as the request. Fills, invalidation and dirty marking take effect at the next rising edge. The bench changes inputs just after a rising edge and compares every output with its behavioural model at the falling edge, before any state change. It then updates the model at the same rising edge that updates the design. This makes effects such as a same-cycle fill being invisible, or a dirty flag appearing one cycle after a write, land in exactly one compared cycle.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W    = 40,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  output logic                  resp_hit,
  output logic [PA_W-1:0]       resp_paddr,
  output logic                  resp_miss_exc,
  output logic                  resp_wprot_exc,
  output logic                  resp_dirty,
  input  logic                  fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  fill_writable,
  input  logic                  inval_all
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, wr_ok, dirty;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];

  logic [ENTRIES-1:0] hit_vec, same_vec;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i]  = vld[i] && (tag[i] == req_vpn);
    assign same_vec[i] = vld[i] && (tag[i] == fill_vpn);
  end

  logic [IDX_W-1:0] hit_idx, same_idx, free_idx;
  always_comb begin
    hit_idx  = '0;
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx  = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
      if (!vld[i])     free_idx = IDX_W'(i);
    end
  end

  wire tag_hit   = |hit_vec;
  wire deny      = req_write && !wr_ok[hit_idx];
  wire fill_same = |same_vec;
  wire any_free  = ~&vld;
  wire do_fill   = fill_valid && !inval_all;
  wire use_rr    = do_fill && !fill_same && !any_free;
  wire mark      = req_valid && tag_hit && req_write && !deny;

  wire [IDX_W-1:0] fill_idx = fill_same ? same_idx : (any_free ? free_idx : rr_ptr);

  assign resp_hit       = req_valid && tag_hit && !deny;
  assign resp_miss_exc  = req_valid && !tag_hit;
  assign resp_wprot_exc = req_valid && tag_hit && deny;
  assign resp_dirty     = req_valid && tag_hit && dirty[hit_idx];
  assign resp_paddr     = resp_hit ? {ppn[hit_idx], req_vaddr[OFF_W-1:0]} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      wr_ok  <= '0;
      dirty  <= '0;
      rr_ptr <= '0;
    end else if (inval_all) begin
      vld   <= '0;
      dirty <= '0;
    end else begin
      if (mark) dirty[hit_idx] <= 1'b1;
      if (do_fill) begin
        vld[fill_idx]   <= 1'b1;
        wr_ok[fill_idx] <= fill_writable;
        dirty[fill_idx] <= 1'b0;
      end
      if (use_rr) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag[fill_idx] <= fill_vpn;
      ppn[fill_idx] <= fill_ppn;
    end
  end

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  a_r3_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss_exc |-> !resp_hit && !resp_wprot_exc && resp_paddr == '0);

  a_r4_wprot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    resp_wprot_exc |-> !resp_hit && resp_paddr == '0);

  a_r5_dirty_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_hit && req_write && !fill_valid && !inval_all) |=> dirty[$past(hit_idx)]);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !resp_hit && !resp_wprot_exc);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !resp_hit && !resp_miss_exc && !resp_wprot_exc && !resp_dirty && resp_paddr == '0);

endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [39:0] req_vaddr = '0;
  logic        fill_valid = 1'b0, fill_writable = 1'b0, inval_all = 1'b0;
  logic [27:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        resp_hit, resp_miss_exc, resp_wprot_exc, resp_dirty;
  logic [31:0] resp_paddr;

  int checks = 0, errors = 0;

  logic        m_vld [N];
  logic        m_wr  [N];
  logic        m_dty [N];
  logic [27:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  int          m_rr;

  always #5 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
    .resp_miss_exc(resp_miss_exc), .resp_wprot_exc(resp_wprot_exc),
    .resp_dirty(resp_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_writable(fill_writable), .inval_all(inval_all)
  );

  function automatic int find(input logic [27:0] v);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int k;
    logic eh, em, ew, ed;
    logic [31:0] ep;
    k = find(req_vaddr[39:12]);
    eh = 0; em = 0; ew = 0; ed = 0; ep = '0;
    if (req_valid) begin
      if (k < 0) em = 1;
      else begin
        ed = m_dty[k];
        if (req_write && !m_wr[k]) ew = 1;
        else begin eh = 1; ep = {m_ppn[k], req_vaddr[11:0]}; end
      end
    end
    chk(tag, "hit", 32'(resp_hit), 32'(eh));
    chk(tag, "miss_exc", 32'(resp_miss_exc), 32'(em));
    chk(tag, "wprot_exc", 32'(resp_wprot_exc), 32'(ew));
    chk(tag, "dirty", 32'(resp_dirty), 32'(ed));
    chk(tag, "paddr", resp_paddr, ep);
  endtask

  task automatic model_update();
    int k, t;
    if (inval_all) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_dty[i] = 0; end
      return;
    end
    k = find(req_vaddr[39:12]);
    if (req_valid && k >= 0 && req_write && m_wr[k]) m_dty[k] = 1;
    if (fill_valid) begin
      t = find(fill_vpn);
      if (t < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) t = i;
        if (t < 0) begin t = m_rr; m_rr = (m_rr + 1) % N; end
      end
      m_vld[t] = 1; m_vpn[t] = fill_vpn; m_ppn[t] = fill_ppn;
      m_wr[t] = fill_writable; m_dty[t] = 0;
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [27:0] vpn, input logic [11:0] off,
                      input logic w, input logic f, input logic [27:0] fv, input logic [19:0] fp,
                      input logic fw, input logic inv);
    req_valid = v; req_vaddr = {vpn, off}; req_write = w;
    fill_valid = f; fill_vpn = fv; fill_ppn = fp; fill_writable = fw; inval_all = inv;
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic look(input string tag, input logic [27:0] vpn, input logic [11:0] off, input logic w);
    step(tag, 1'b1, vpn, off, w, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(input string tag, input logic [27:0] vpn, input logic [19:0] p, input logic wr);
    step(tag, 1'b0, '0, '0, 1'b0, 1'b1, vpn, p, wr, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_wr[i] = 0; m_dty[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    m_rr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    look("R1", 28'h0000000, 12'h000, 1'b0);
    look("R1", 28'hABCDEF1, 12'h123, 1'b1);
    // R11 idle
    step("R11", 1'b0, 28'h0000001, 12'h555, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    // R10 lookup during fill sees old contents
    step("R10", 1'b1, 28'h0000001, 12'h010, 1'b0, 1'b1, 28'h0000001, 20'h11111, 1'b1, 1'b0);
    // R2 hits with several offsets
    look("R2", 28'h0000001, 12'h000, 1'b0);
    look("R2", 28'h0000001, 12'hFFF, 1'b0);
    look("R2", 28'h0000001, 12'hA5C, 1'b0);
    look("R3", 28'h0000002, 12'h001, 1'b0);
    // R4 write protection
    fill("R4", 28'h0000002, 20'h22222, 1'b0);
    look("R4", 28'h0000002, 12'h3C0, 1'b1);
    look("R4", 28'h0000002, 12'h3C0, 1'b0);
    // R5 dirty marking
    look("R5", 28'h0000001, 12'h004, 1'b1);
    look("R5", 28'h0000001, 12'h008, 1'b0);
    look("R5", 28'h0000001, 12'h00C, 1'b1);
    // R8 refill of a resident page
    fill("R8", 28'h0000001, 20'h33333, 1'b0);
    look("R8", 28'h0000001, 12'h777, 1'b0);
    look("R8", 28'h0000001, 12'h777, 1'b1);
    // R6 fill up to capacity
    for (int i = 0; i < N - 2; i++) fill("R6", 28'h0100000 + 28'(i), 20'h40000 + 20'(i), i[0]);
    for (int i = 0; i < N - 2; i++) look("R6", 28'h0100000 + 28'(i), 12'(i * 37), 1'b1);
    look("R6", 28'h0000001, 12'h001, 1'b0);
    look("R6", 28'h0000002, 12'h002, 1'b0);
    // R7 round-robin replacement
    fill("R7", 28'h0200000, 20'h55555, 1'b1);
    look("R7", 28'h0000001, 12'h000, 1'b0);
    look("R7", 28'h0200000, 12'h0AB, 1'b0);
    look("R7", 28'h0000002, 12'h000, 1'b0);
    fill("R7", 28'h0200001, 20'h55556, 1'b1);
    look("R7", 28'h0000002, 12'h000, 1'b0);
    look("R7", 28'h0100000, 12'h000, 1'b0);
    fill("R7", 28'h0200002, 20'h55557, 1'b1);
    look("R7", 28'h0100000, 12'h000, 1'b0);
    look("R7", 28'h0100001, 12'h000, 1'b0);
    // R9 invalidate-all beats a same-cycle fill
    step("R9", 1'b1, 28'h0200000, 12'h001, 1'b0, 1'b1, 28'h0300000, 20'h66666, 1'b1, 1'b1);
    look("R9", 28'h0300000, 12'h001, 1'b0);
    look("R9", 28'h0200000, 12'h001, 1'b0);
    look("R9", 28'h0100005, 12'h001, 1'b1);
    // refill after flush, mixed traffic
    fill("R6", 28'h0400000, 20'h77777, 1'b1);
    for (int i = 0; i < 40; i++) begin
      step("R2", 1'b1, (i % 3 == 0) ? 28'h0400000 : 28'h0400000 + 28'(i), 12'(i * 101), i[1],
           i[2], 28'h0400000 + 28'(i), 20'h78000 + 20'(i), i[0], 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule